// File: doc/BRIEF.md
# Eight-Point Forward DCT with Even/Odd Split

This block computes a one-dimensional eight-point forward discrete cosine transform on one row or column of an image block. It accepts eight unsigned pixel samples in parallel, moves them to a signed range centred on zero, and returns eight signed frequency coefficients in parallel. A second instance, or a second pass through a transpose buffer, gives the two-dimensional transform.

The first stage uses adders only. It folds the vector about its centre: the sums of mirrored sample pairs feed the even-index coefficients, and the differences of those pairs feed the odd-index coefficients. Each half is then a 4x4 constant matrix, so 32 constant multiplies produce all eight outputs instead of 64. The cosine constants are integers scaled by 1024. Each dot product is rounded and shifted right by ten bits. The overall factor of one half is left out.

A new vector may be presented on every clock cycle. The results appear two cycles later with a matching valid strobe, and they stay on the output until the next result replaces them.

Top module: `dct8_ee`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is low and `out_coef` is all zero.
- R2: `out_valid` is `in_valid` delayed by exactly two clock cycles. Every valid vector produces exactly one result.
- R3: Each sample p is treated as x = p - 128. A vector whose eight samples are all 128 gives eight zero coefficients.
- R4: Sample k occupies `in_pix[8k+7:8k]`. Coefficient n is a 14-bit two's-complement field at `out_coef[14n+13:14n]`. The even coefficients 0, 2, 4 and 6 are computed from s_k = x_k + x_(7-k), for k = 0..3.
- R5: The odd coefficients 1, 3, 5 and 7 are computed from d_k = x_k - x_(7-k), for k = 0..3.
- R6: Before rounding, coefficient n equals the sum over m = 0..7 of C(n,m)*x_m. For n > 0, C(n,m) is the cosine of n(2m+1)π/16 multiplied by 1024 and rounded to the nearest integer. For n = 0, every C(0,m) is 724, which is 1024/sqrt(2) rounded.
- R7: Each sum A is rescaled to floor((A + 512) / 1024), an arithmetic right shift by ten bits after adding half an output unit.
- R8: On cycles that do not carry a new result, `out_coef` keeps its previous value. Samples presented with `in_valid` low have no effect on any output.
- R9: A mirror-symmetric input (p_k = p_(7-k)) gives zero odd coefficients. A mirror-antisymmetric input (p_k + p_(7-k) = 256) gives zero even coefficients.
- R10: Full-scale inputs do not wrap. All samples 255 give coefficient 0 = 718. All samples 0 give -724. All other coefficients are 0 in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The sample vector on `in_pix` is valid this cycle |
| in_pix | input | 64 | Eight unsigned 8-bit samples; sample k in bits 8k+7..8k |
| out_valid | output | 1 | `out_coef` carries a new result this cycle |
| out_coef | output | 112 | Eight signed 14-bit coefficients; coefficient n in bits 14n+13..14n |

## Verification
The properties assume that `in_valid` is a clean, known level on every rising edge after reset, and that each of the eight samples lies within its 8-bit unsigned field. No other input handshake or ordering is required, so any valid pattern is legal, including back-to-back vectors and long gaps. The stimulus keeps `in_valid` and `in_pix` at known values from time zero. It changes them only on the falling edge. It mixes fully random samples with symmetric, antisymmetric, impulse, ramp and full-scale vectors, so every input stays inside the 0..255 range that the fold and the widths are sized for.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
   localparam int NPT        = 8;
   localparam int HALF       = NPT / 2;
   localparam int COEF_W     = 12;
   localparam int TABLE_FRAC = 10;

   // cos(j*pi/16) scaled by 2^TABLE_FRAC, folded into the first quadrant
   function automatic int cos_q(input int j);
      int a;
      int sgn;
      int mag;
      a   = j % 32;
      sgn = 1;
      if (a > 16) a = 32 - a;
      if (a > 8) begin
         a   = 16 - a;
         sgn = -1;
      end
      case (a)
         0:       mag = 1024;
         1:       mag = 1004;
         2:       mag = 946;
         3:       mag = 851;
         4:       mag = 724;
         5:       mag = 569;
         6:       mag = 392;
         7:       mag = 200;
         default: mag = 0;
      endcase
      return sgn * mag;
   endfunction

   // constant applied to folded term k for output row n
   function automatic int half_coef(input int n, input int k);
      if (n == 0) return cos_q(4);
      return cos_q(n * (2 * k + 1));
   endfunction
endpackage

// File: rtl/dct8_prestage.sv
module dct8_prestage
   import dct8_pkg::*;
#(
   parameter  int PIX_W = 8,
   localparam int SUM_W = PIX_W + 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [NPT*PIX_W-1:0]          in_pix,
   output logic                          pre_valid,
   output logic [HALF-1:0][SUM_W-1:0]    sum_q,
   output logic [HALF-1:0][SUM_W-1:0]    dif_q
);
   // the offset of both mirrored samples, removed from each sum
   localparam logic [SUM_W-1:0] MID2 = SUM_W'(1) << PIX_W;

   logic [HALF-1:0][SUM_W-1:0] sum_d;
   logic [HALF-1:0][SUM_W-1:0] dif_d;

   for (genvar k = 0; k < HALF; k++) begin : g_fold
      logic [PIX_W-1:0] lo;
      logic [PIX_W-1:0] hi;
      assign lo = in_pix[k*PIX_W +: PIX_W];
      assign hi = in_pix[(NPT-1-k)*PIX_W +: PIX_W];
      assign sum_d[k] = SUM_W'(lo) + SUM_W'(hi) - MID2;
      assign dif_d[k] = SUM_W'(lo) - SUM_W'(hi);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_valid <= 1'b0;
         sum_q     <= '0;
         dif_q     <= '0;
      end else begin
         pre_valid <= in_valid;
         if (in_valid) begin
            sum_q <= sum_d;
            dif_q <= dif_d;
         end
      end
   end
endmodule

// File: rtl/dct8_rowsum.sv
module dct8_rowsum
   import dct8_pkg::*;
#(
   parameter  int SUM_W         = 10,
   parameter  int FRAC_W        = 10,
   parameter  int ROW           = 0,
   parameter  bit ROUND_NEAREST = 1'b1,
   localparam int ACC_W         = SUM_W + COEF_W + 2,
   localparam int OUT_W         = ACC_W - FRAC_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic [HALF-1:0][SUM_W-1:0] vec,
   output logic [OUT_W-1:0]           coef
);
   logic signed [ACC_W-1:0] prod [HALF];
   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] rnd;
   logic        [OUT_W-1:0] coef_d;

   for (genvar k = 0; k < HALF; k++) begin : g_mul
      localparam logic signed [ACC_W-1:0] CK = ACC_W'(half_coef(ROW, k));
      logic signed [SUM_W-1:0] sv;
      assign sv      = vec[k];
      assign prod[k] = sv * CK;
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < HALF; k++) acc = acc + prod[k];
   end

   if (ROUND_NEAREST) begin : g_round
      localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (FRAC_W - 1);
      assign rnd = acc + HALF_LSB;
   end else begin : g_trunc
      assign rnd = acc;
   end

   assign coef_d = OUT_W'(rnd >>> FRAC_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  coef <= '0;
      else if (en) coef <= coef_d;
   end
endmodule

// File: rtl/dct8_ee.sv
module dct8_ee
   import dct8_pkg::*;
#(
   parameter  int PIX_W         = 8,
   parameter  int FRAC_W        = 10,
   parameter  bit ROUND_NEAREST = 1'b1,
   localparam int SUM_W         = PIX_W + 2,
   localparam int ACC_W         = SUM_W + COEF_W + 2,
   localparam int OUT_W         = ACC_W - FRAC_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [NPT*PIX_W-1:0]   in_pix,
   output logic                   out_valid,
   output logic [NPT*OUT_W-1:0]   out_coef
);
   if (FRAC_W != TABLE_FRAC) begin : g_bad_frac
      $error("dct8_ee: FRAC_W must match the constant table scale");
   end
   if (PIX_W < 2 || PIX_W > 16) begin : g_bad_pix
      $error("dct8_ee: PIX_W out of supported range");
   end

   logic                       pre_valid;
   logic [HALF-1:0][SUM_W-1:0] sum_q;
   logic [HALF-1:0][SUM_W-1:0] dif_q;
   logic                       res_valid;

   dct8_prestage #(.PIX_W(PIX_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_pix    (in_pix),
      .pre_valid (pre_valid),
      .sum_q     (sum_q),
      .dif_q     (dif_q)
   );

   for (genvar n = 0; n < NPT; n++) begin : g_row
      logic [HALF-1:0][SUM_W-1:0] src;
      if (n % 2 == 0) begin : g_even
         assign src = sum_q;
      end else begin : g_odd
         assign src = dif_q;
      end
      dct8_rowsum #(
         .SUM_W         (SUM_W),
         .FRAC_W        (FRAC_W),
         .ROW           (n),
         .ROUND_NEAREST (ROUND_NEAREST)
      ) u_row (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (pre_valid),
         .vec   (src),
         .coef  (out_coef[n*OUT_W +: OUT_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_valid <= 1'b0;
      else        res_valid <= pre_valid;
   end

   assign out_valid = res_valid;
endmodule

// File: rtl/dct8_ee_chk.sv
module dct8_ee_chk #(
   parameter int PIX_W = 8,
   parameter int OUT_W = 14,
   parameter int NPT   = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [NPT*PIX_W-1:0] in_pix,
   input logic                 out_valid,
   input logic [NPT*OUT_W-1:0] out_coef
);
   localparam logic [PIX_W-1:0] MID = PIX_W'(1) << (PIX_W - 1);

   logic [1:0] since_rst;
   logic       sym_in;
   logic       anti_in;
   logic       odd_zero;
   logic       even_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   always_comb begin
      sym_in  = 1'b1;
      anti_in = 1'b1;
      for (int k = 0; k < NPT / 2; k++) begin
         if (in_pix[k*PIX_W +: PIX_W] != in_pix[(NPT-1-k)*PIX_W +: PIX_W]) sym_in = 1'b0;
         if ((PIX_W+1)'(in_pix[k*PIX_W +: PIX_W]) + (PIX_W+1)'(in_pix[(NPT-1-k)*PIX_W +: PIX_W])
             != ((PIX_W+1)'(1) << PIX_W)) anti_in = 1'b0;
      end
      odd_zero  = 1'b1;
      even_zero = 1'b1;
      for (int n = 0; n < NPT; n++) begin
         if (out_coef[n*OUT_W +: OUT_W] != '0) begin
            if (n % 2 == 1) odd_zero = 1'b0;
            else            even_zero = 1'b0;
         end
      end
   end

   // R1: outputs idle while and just after reset
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_coef == '0));

   // R2: valid travels with a fixed two-cycle latency
   a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      since_rst == 2'd3 |-> out_valid == $past(in_valid, 2));

   // R8: no new result means the coefficients hold
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && !$past(in_valid, 2)) |-> $stable(out_coef));

   // R3: a flat mid-gray vector transforms to zero
   a_r3_mid_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && $past(in_valid, 2) && $past(in_pix, 2) == {NPT{MID}})
      |-> out_coef == '0);

   // R9: mirror symmetry clears the odd half
   a_r9_sym_odd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && $past(in_valid, 2) && $past(sym_in, 2)) |-> odd_zero);

   // R9: mirror antisymmetry clears the even half
   a_r9_anti_even_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && $past(in_valid, 2) && $past(anti_in, 2)) |-> even_zero);
endmodule

bind dct8_ee dct8_ee_chk #(
   .PIX_W (PIX_W),
   .OUT_W (OUT_W),
   .NPT   (dct8_pkg::NPT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_pix    (in_pix),
   .out_valid (out_valid),
   .out_coef  (out_coef)
);

// File: tb/dct8_ee_tb.sv
module dct8_ee_tb;
   localparam int PIX_W = 8;
   localparam int NPT   = 8;
   localparam int OUT_W = 14;
   localparam int VW    = NPT * PIX_W;
   localparam int CW    = NPT * OUT_W;

   logic          clk      = 1'b0;
   logic          rst_n    = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] in_pix   = '0;
   logic          out_valid;
   logic [CW-1:0] out_coef;

   always #10 clk = ~clk;

   dct8_ee u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_pix    (in_pix),
      .out_valid (out_valid),
      .out_coef  (out_coef)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic          pv [2];
   logic [CW-1:0] pe [2];
   string         pt [2];
   logic [CW-1:0] last_exp;

   function automatic int rnd_int(input real r);
      if (r >= 0.0) return $rtoi(r + 0.5);
      return -$rtoi(-r + 0.5);
   endfunction

   // R6: constant matrix from the cosine definition
   function automatic int cmat(input int n, input int m);
      real r;
      if (n == 0) r = 1024.0 / $sqrt(2.0);
      else        r = 1024.0 * $cos(n * (2 * m + 1) * 3.14159265358979 / 16.0);
      return rnd_int(r);
   endfunction

   // direct 8x8 form, centring (R3) and round-half-up rescale (R7)
   function automatic logic [CW-1:0] ref_out(input logic [VW-1:0] pix);
      logic [CW-1:0] r;
      r = '0;
      for (int n = 0; n < NPT; n++) begin
         longint acc;
         longint res;
         acc = 0;
         for (int m = 0; m < NPT; m++)
            acc += longint'(cmat(n, m)) * (longint'(pix[m*PIX_W +: PIX_W]) - 128);
         res = (acc + 512) >>> 10;
         r[n*OUT_W +: OUT_W] = OUT_W'(res);
      end
      return r;
   endfunction

   task automatic step(input logic v, input logic [VW-1:0] pix, input string tag);
      logic [CW-1:0] want;
      string         wtag;
      checks++;
      if (out_valid !== pv[1]) begin
         fails++;
         $display("FAIL R2 out_valid actual=%b expected=%b", out_valid, pv[1]);
      end
      want = pv[1] ? pe[1] : last_exp;
      wtag = pv[1] ? pt[1] : "R8";
      checks++;
      if (out_coef !== want) begin
         fails++;
         $display("FAIL %s out_coef actual=%h expected=%h", wtag, out_coef, want);
      end
      if (pv[1]) last_exp = pe[1];
      pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
      pv[0] = v;     pe[0] = ref_out(pix); pt[0] = tag;
      in_valid = v;
      in_pix   = pix;
      @(negedge clk);
   endtask

   function automatic logic [VW-1:0] rand_vec();
      logic [VW-1:0] r;
      for (int k = 0; k < NPT; k++) r[k*PIX_W +: PIX_W] = PIX_W'($urandom_range(0, 255));
      return r;
   endfunction

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] v;
      void'($urandom(32'h5eed_0d17));
      pv[0] = 1'b0; pv[1] = 1'b0; pe[0] = '0; pe[1] = '0; pt[0] = ""; pt[1] = "";
      last_exp = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid !== 1'b0 || out_coef !== '0) begin
         fails++;
         $display("FAIL R1 reset outputs actual=%b/%h expected=0/0", out_valid, out_coef);
      end
      rst_n = 1'b1;
      @(negedge clk);

      step(1'b1, {NPT{8'd128}}, "R3");
      step(1'b1, {NPT{8'd255}}, "R10");
      step(1'b1, {NPT{8'd0}},   "R10");
      for (int k = 0; k < NPT; k++) v[k*PIX_W +: PIX_W] = (k % 2 == 0) ? 8'd255 : 8'd0;
      step(1'b1, v, "R10 R5");
      v = {NPT{8'd128}}; v[7:0] = 8'd255;
      step(1'b1, v, "R6");
      v = {NPT{8'd128}}; v[3*PIX_W +: PIX_W] = 8'd0;
      step(1'b1, v, "R6");
      for (int k = 0; k < NPT; k++) v[k*PIX_W +: PIX_W] = PIX_W'(k * 32);
      step(1'b1, v, "R5");
      // R8: samples changing while valid is low must be ignored
      for (int i = 0; i < 4; i++) step(1'b0, rand_vec(), "R8");

      for (int i = 0; i < 20; i++) begin
         for (int k = 0; k < NPT / 2; k++) begin
            v[k*PIX_W +: PIX_W]         = PIX_W'($urandom_range(0, 255));
            v[(NPT-1-k)*PIX_W +: PIX_W] = v[k*PIX_W +: PIX_W];
         end
         step(1'b1, v, "R9 R4");
      end
      for (int i = 0; i < 20; i++) begin
         for (int k = 0; k < NPT / 2; k++) begin
            int r;
            r = $urandom_range(1, 255);
            v[k*PIX_W +: PIX_W]         = PIX_W'(r);
            v[(NPT-1-k)*PIX_W +: PIX_W] = PIX_W'(256 - r);
         end
         step(1'b1, v, "R9 R5");
      end
      // random mix with gaps: R2 latency, R4/R5 halves, R7 rounding
      for (int i = 0; i < 300; i++)
         step(($urandom_range(0, 3) != 0), rand_vec(), "R4 R5 R7");
      for (int i = 0; i < 4; i++) step(1'b0, rand_vec(), "R8");

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule